// File: doc/BRIEF.md
# Load/Store Bus Lane Aligner

This block connects a 32-bit load/store unit to a 32-bit system data bus with a single master. It accepts one request at a time. Each request carries an address, a two-bit size code, a write flag and the source register value. The block holds the request and presents it to the bus until the target signals ready. On a store it puts the whole source register on the data lines, unchanged, whatever the size, and reports the width only on the separate size lines. Narrowing the data is left to the target. On a load it samples the full bus word, because targets return data on the byte lanes that match the address. It then shifts and masks that word on the CPU side, so the addressed byte or halfword arrives right-aligned and zero-extended at the register file.

Control is a three-state machine. In IDLE the block is ready for a request. The transition IDLE->BUS fires when a request is accepted. In BUS the block drives the bus and waits for ready. The transition BUS->IDLE fires when a store completes, and BUS->RESP fires when load data is captured. RESP presents the aligned load result for exactly one cycle, and the transition RESP->IDLE then returns the block to the ready state.

Top module: `lsu_lane_aligner`

## Requirements
- R1: After reset, req_ready is 1, bus_valid is 0 and rsp_valid is 0.
- R2: A request is accepted in a cycle where req_valid and req_ready are both 1. In the next cycle bus_valid is 1, req_ready is 0, and bus_addr, bus_write and bus_wdata carry the accepted request's values.
- R3: While bus_valid is 1 and bus_ready is 0, bus_valid stays at 1 and bus_addr, bus_size, bus_write and bus_wdata do not change.
- R4: On a store, bus_wdata equals the full 32-bit request data for every size code. A byte store of 0x12345678 drives 0x12345678. A store produces no rsp_valid pulse, and req_ready returns to 1 in the cycle after bus_ready is seen.
- R5: The size codes are 2'b00 for byte, 2'b01 for halfword and 2'b10 for word. A request with the reserved code 2'b11 is driven out as 2'b10 and loaded as a word.
- R6: For a byte load, rsp_rdata = (captured word >> (addr[1:0]*8)) & 0xFF.
- R7: For a halfword load, rsp_rdata = (captured word >> (addr[1]*16)) & 0xFFFF. Address bit 0 has no effect on the result.
- R8: For a word load, rsp_rdata equals the captured word unchanged.
- R9: Load data is captured from bus_rdata in the cycle where bus_valid and bus_ready are both 1. rsp_valid is 1 for exactly the following cycle. A later change on bus_rdata does not alter rsp_rdata.
- R10: bus_addr carries the full request address, including the low bits below the access size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Request byte address |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_wdata | input | 32 | Source register value for a store |
| bus_valid | output | 1 | Bus access in progress |
| bus_ready | input | 1 | Target completes the access |
| bus_addr | output | 32 | Bus address |
| bus_size | output | 2 | Bus access size code |
| bus_write | output | 1 | Bus write flag |
| bus_wdata | output | 32 | Bus write data, full register value |
| bus_rdata | input | 32 | Bus read word, data on address-matching lanes |
| rsp_valid | output | 1 | Aligned load result present |
| rsp_rdata | output | 32 | Right-aligned, zero-extended load result |

## Verification
The bench builds the block with the default address and data widths of 32 bits. This gives four byte lanes, so every low-address offset can be combined with every size code, the reserved one included. Bus wait times range from zero to several cycles, which brings the hold and the single-cycle capture within reach. The bench also changes bus_rdata right after the ready cycle, so a late capture would show up at the result.

// File: rtl/lane_pkg.sv
package lane_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_BUS  = 2'b01,
        ST_RESP = 2'b10
    } ctl_state_e;

    function automatic acc_size_e fold_size(input logic [1:0] code);
        acc_size_e r;
        unique case (code)
            2'b00:   r = SZ_BYTE;
            2'b01:   r = SZ_HALF;
            default: r = SZ_WORD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lane_ctrl_fsm.sv
module lane_ctrl_fsm
    import lane_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       bus_ready,
    input  logic       op_write,
    output ctl_state_e state,
    output logic       take_req,
    output logic       take_data,
    output logic       drive_bus,
    output logic       emit_rsp,
    output logic       idle
);

    ctl_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_BUS;
            ST_BUS:  if (bus_ready) state_nx = op_write ? ST_IDLE : ST_RESP;
            ST_RESP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        idle      = 1'b0;
        drive_bus = 1'b0;
        emit_rsp  = 1'b0;
        take_req  = 1'b0;
        take_data = 1'b0;
        unique case (state)
            ST_IDLE: begin
                idle     = 1'b1;
                take_req = req_valid;
            end
            ST_BUS: begin
                drive_bus = 1'b1;
                take_data = bus_ready && !op_write;
            end
            ST_RESP: emit_rsp = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/lane_req_hold.sv
module lane_req_hold
    import lane_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_req,
    input  logic          take_data,
    input  logic [AW-1:0] in_addr,
    input  logic [1:0]    in_size,
    input  logic          in_write,
    input  logic [DW-1:0] in_wdata,
    input  logic [DW-1:0] in_rword,
    output logic [AW-1:0] hold_addr,
    output acc_size_e     hold_size,
    output logic          hold_write,
    output logic [DW-1:0] hold_wdata,
    output logic [DW-1:0] hold_rword
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr  <= '0;
            hold_size  <= SZ_BYTE;
            hold_write <= 1'b0;
            hold_wdata <= '0;
        end else if (take_req) begin
            hold_addr  <= in_addr;
            hold_size  <= fold_size(in_size);
            hold_write <= in_write;
            hold_wdata <= in_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         hold_rword <= '0;
        else if (take_data) hold_rword <= in_rword;
    end

endmodule

// File: rtl/lane_extract.sv
module lane_extract
    import lane_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]                 word_in,
    input  logic [$clog2(DW/8)-1:0]       offset,
    input  acc_size_e                     size,
    output logic [DW-1:0]                 aligned
);

    localparam int LANES = DW / 8;
    localparam int LB    = $clog2(LANES);

    logic [LB-1:0]    lane_off;
    int unsigned      width_bytes;
    logic [DW-1:0]    shifted;
    logic [LANES-1:0] lane_keep;
    logic [DW-1:0]    keep_mask;

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                lane_off    = offset;
                width_bytes = 1;
            end
            SZ_HALF: begin
                lane_off    = offset & ~LB'(1);
                width_bytes = 2;
            end
            default: begin
                lane_off    = offset & ~LB'(3);
                width_bytes = 4;
            end
        endcase
    end

    assign shifted = word_in >> {lane_off, 3'b000};

    always_comb begin
        for (int i = 0; i < LANES; i++) lane_keep[i] = (i < width_bytes);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign keep_mask[g*8 +: 8] = {8{lane_keep[g]}};
    end

    assign aligned = shifted & keep_mask;

endmodule

// File: rtl/lsu_lane_aligner.sv
module lsu_lane_aligner
    import lane_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic          req_write,
    input  logic [DW-1:0] req_wdata,
    output logic          bus_valid,
    input  logic          bus_ready,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic          bus_write,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);

    localparam int LB = $clog2(DW / 8);

    ctl_state_e    state;
    logic          take_req, take_data;
    acc_size_e     hold_size;
    logic [DW-1:0] hold_rword;

    lane_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bus_ready (bus_ready),
        .op_write  (bus_write),
        .state     (state),
        .take_req  (take_req),
        .take_data (take_data),
        .drive_bus (bus_valid),
        .emit_rsp  (rsp_valid),
        .idle      (req_ready)
    );

    lane_req_hold #(.AW(AW), .DW(DW)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_req   (take_req),
        .take_data  (take_data),
        .in_addr    (req_addr),
        .in_size    (req_size),
        .in_write   (req_write),
        .in_wdata   (req_wdata),
        .in_rword   (bus_rdata),
        .hold_addr  (bus_addr),
        .hold_size  (hold_size),
        .hold_write (bus_write),
        .hold_wdata (bus_wdata),
        .hold_rword (hold_rword)
    );

    assign bus_size = hold_size;

    lane_extract #(.DW(DW)) u_extract (
        .word_in (hold_rword),
        .offset  (bus_addr[LB-1:0]),
        .size    (hold_size),
        .aligned (rsp_rdata)
    );

    // R2: an accepted request appears on the bus in the next cycle
    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (bus_valid && !req_ready && bus_addr == $past(req_addr)));

    // R3: bus outputs hold while the target stalls
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_wdata)
                                       && $stable(bus_size) && $stable(bus_write)));

    // R4: store data leaves the block untouched
    assert_store_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> (bus_wdata == $past(req_wdata)));

    // R5: the reserved size code never reaches the bus
    assert_size_fold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_size != 2'b11));

    // R9: load result follows the ready cycle and lasts one cycle
    assert_rsp_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && !bus_write) |=> rsp_valid);
    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6: byte results are zero-extended
    assert_byte_zext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && hold_size == SZ_BYTE) |-> (rsp_rdata[DW-1:8] == '0));

endmodule

// File: tb/sim_lsu_lane_aligner.sv
module sim_lsu_lane_aligner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        bus_valid;
    logic        bus_ready = 1'b0;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic        bus_write;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    lsu_lane_aligner u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_write(bus_write), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // behavioural reference: 0 idle, 1 on bus, 2 result
    int          m_phase = 0;
    logic [31:0] m_addr, m_wdata, m_word;
    int          m_size;
    logic        m_write;

    always @(posedge clk) begin
        if (!rst_n) m_phase = 0;
        else case (m_phase)
            0: if (req_valid) begin
                m_addr = req_addr; m_size = int'(req_size); m_write = req_write;
                m_wdata = req_wdata; m_phase = 1;
            end
            1: if (bus_ready) begin
                if (m_write) m_phase = 0;
                else begin m_word = bus_rdata; m_phase = 2; end
            end
            default: m_phase = 0;
        endcase
    end

    function automatic logic [31:0] expect_load(logic [31:0] w, logic [31:0] a, int sz);
        if (sz == 0) return (w >> ((a % 4) * 8)) & 32'hFF;
        if (sz == 1) return (w >> ((a & 2) * 8)) & 32'hFFFF;
        return w;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cycles++;
            check("R1/R2 req_ready", 32'(req_ready), 32'(m_phase == 0));
            check("R2 bus_valid", 32'(bus_valid), 32'(m_phase == 1));
            check("R9 rsp_valid", 32'(rsp_valid), 32'(m_phase == 2));
            if (m_phase == 1) begin
                check("R10 bus_addr", bus_addr, m_addr);
                check("R4 bus_wdata", bus_wdata, m_wdata);
                check("R2 bus_write", 32'(bus_write), 32'(m_write));
                check("R5 bus_size", 32'(bus_size), (m_size == 3) ? 32'd2 : 32'(m_size));
            end
            if (m_phase == 2) begin
                if (m_size == 0)      check("R6 byte load", rsp_rdata, expect_load(m_word, m_addr, 0));
                else if (m_size == 1) check("R7 half load", rsp_rdata, expect_load(m_word, m_addr, 1));
                else                  check("R8/R5 word load", rsp_rdata, expect_load(m_word, m_addr, 2));
            end
        end
    end

    task automatic access(logic [31:0] a, logic [1:0] sz, logic wr,
                          logic [31:0] wd, logic [31:0] rw, int waits);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~wd;
        for (int i = 0; i < waits; i++) begin
            bus_rdata = rw ^ 32'hA5A5_0F0F;
            @(negedge clk);
        end
        bus_ready = 1'b1; bus_rdata = rw;
        @(negedge clk);
        bus_ready = 1'b0; bus_rdata = ~rw;   // R9: late change must not leak
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (!(req_ready === 1'b1 && bus_valid === 1'b0 && rsp_valid === 1'b0)) begin
            errors++;
            $display("FAIL R1 reset state: got %b%b%b expected 100", req_ready, bus_valid, rsp_valid);
        end
        rst_n = 1'b1;
        // R4 byte store keeps the full register
        access(32'h1000_0003, 2'b00, 1'b1, 32'h1234_5678, 32'h0, 0);
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 4; o++)
                for (int w = 0; w < 2; w++)
                    access(32'h8000_0000 + 32'(o) + 32'(s * 16), 2'(s), w[0],
                           32'hC0DE_0000 + 32'(s * 8 + o), 32'h8899_AABB ^ 32'(o << (s * 4)),
                           (s + o + w) % 4);
        access(32'h0000_0003, 2'b00, 1'b0, 32'h0, 32'hF100_0000, 2); // R6 top lane
        access(32'h0000_0001, 2'b01, 1'b0, 32'h0, 32'hDEAD_BEEF, 0); // R7 bit 0 ignored
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule